// File: doc/BRIEF.md
# Port-Size Adapting Beat Sequencer

This block turns one bus transfer from an internal master into a series of beats on an external memory port that may be narrower than the transfer. A request carries a start address, a transfer size code and a code for the port width of the device being reached. The block works out how many beats the port needs, steps the beat address, and drives a byte-lane select mask on every beat.

Each beat on which data crosses the bus raises a data-valid strobe. A separate termination acknowledge rises only on the last beat, together with that beat's data-valid strobe. A narrow port therefore sees several valid-only beats followed by one terminating beat. The memory side stalls the sequence with a ready input.

The request side is a valid/ready handshake. A request is taken in the cycle in which `req_valid` and `req_ready` are both high. `req_ready` is low for the whole of a transfer, so a waiting master must hold its request stable until it is taken. On the memory side `mem_ready` is the only back-pressure: a low `mem_ready` freezes the sequence where it stands.

Top module: `beat_sequencer`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is accepted when `req_valid` and `req_ready` are both high. `busy` is high from the next cycle through the acknowledge cycle and low in the cycle after the acknowledge.
- R2: `req_size` codes 0, 1, 2, 3 and 4 mean transfers of 1, 2, 4, 8 and 16 bytes, and any code above 4 is treated as 4. `req_port` codes 0, 1, 2 and 3 mean ports of 8, 16, 32 and 64 bits.
- R3: The beat width is the smaller of the transfer bytes and the port bytes. A transfer has transfer-bytes / beat-width beats, so at least one, and `beat_valid` is high on exactly that many cycles.
- R4: `xfer_ack` is high only on the final beat of a transfer, exactly once per transfer, and always in a cycle in which `beat_valid` is high.
- R5: The first beat address is `req_addr` with its low log2(beat width) bits cleared. Each completed beat adds the beat width to the address, wrapping inside the transfer-size-aligned block.
- R6: While busy, `lane_sel` bit i (i = byte lane 0..7) is high exactly for i in [off, off + beat width), where off = `beat_addr` mod port bytes. While idle, `lane_sel` is all zero.
- R7: While `mem_ready` is low, `beat_valid` and `xfer_ack` stay low and the beat address and beat count hold.
- R8: After reset the block is idle, with `busy`, `beat_valid`, `xfer_ack` and `lane_sel` all low and `req_ready` high.
- R9: A request arriving while busy is ignored: the transfer in progress goes on with its own address and lanes.
- R10: A 16-byte transfer to a 32-bit port gives three beats with `beat_valid` alone, then a fourth beat with both `beat_valid` and `xfer_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 3 | Transfer size code (log2 bytes) |
| req_port | input | 2 | Target port width code (log2 bytes) |
| mem_ready | input | 1 | Memory side can move a beat this cycle |
| busy | output | 1 | Transfer in progress |
| beat_addr | output | ADDR_W | Address of the current beat |
| lane_sel | output | LANES | Byte-lane selects of the current beat |
| beat_valid | output | 1 | Data moves on this beat |
| xfer_ack | output | 1 | Final beat, transfer ends |

## Verification
The bench builds the block with its defaults: a 32-bit address, eight byte lanes and a 16-byte largest transfer. With those values every port width from 8 to 64 bits can be reached, and the lane masks can fall at any offset within the 64-bit bus. Transfers can run from one beat up to sixteen beats, which brings address wrap-around inside a 16-byte block and size-code clamping within reach. The wait-state patterns stall both intermediate beats and the final beat.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    BSQ_IDLE = 1'b0,
    BSQ_RUN  = 1'b1
  } bsq_state_e;

  localparam int unsigned BSQ_LOG_W = 3;
endpackage

// File: rtl/bsq_req_decode.sv
module bsq_req_decode
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LANES    = 8,
  parameter int unsigned SIZE_MAX = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [2:0]           size_code,
  input  logic [1:0]           port_code,
  output logic [ADDR_W-1:0]    start_addr,
  output logic [BSQ_LOG_W-1:0] xfer_log,
  output logic [BSQ_LOG_W-1:0] port_log,
  output logic [BSQ_LOG_W-1:0] beat_log,
  output logic [SIZE_MAX:0]    beats_m1
);
  localparam int unsigned LANE_LOG = $clog2(LANES);
  localparam int unsigned CNT_W    = SIZE_MAX + 1;
  localparam logic [BSQ_LOG_W-1:0] SIZE_CAP = BSQ_LOG_W'(SIZE_MAX);
  localparam logic [BSQ_LOG_W-1:0] PORT_CAP = BSQ_LOG_W'(LANE_LOG);

  logic [BSQ_LOG_W-1:0] sz_l, pt_l, bt_l, diff;

  always_comb begin
    sz_l = (BSQ_LOG_W'(size_code) > SIZE_CAP) ? SIZE_CAP : BSQ_LOG_W'(size_code);
    pt_l = (BSQ_LOG_W'(port_code) > PORT_CAP) ? PORT_CAP : BSQ_LOG_W'(port_code);
    bt_l = (sz_l < pt_l) ? sz_l : pt_l;
    diff = sz_l - bt_l;
  end

  assign xfer_log   = sz_l;
  assign port_log   = pt_l;
  assign beat_log   = bt_l;
  assign beats_m1   = (CNT_W'(1) << diff) - CNT_W'(1);
  assign start_addr = addr & ({ADDR_W{1'b1}} << bt_l);
endmodule

// File: rtl/bsq_beat_ctrl.sv
module bsq_beat_ctrl
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SIZE_MAX = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [BSQ_LOG_W-1:0] xfer_log,
  input  logic [BSQ_LOG_W-1:0] port_log,
  input  logic [BSQ_LOG_W-1:0] beat_log,
  input  logic [SIZE_MAX:0]    beats_m1,
  input  logic                 mem_ready,
  output logic                 busy,
  output logic [ADDR_W-1:0]    beat_addr,
  output logic [BSQ_LOG_W-1:0] port_log_q,
  output logic [BSQ_LOG_W-1:0] beat_log_q,
  output logic                 beat_valid,
  output logic                 xfer_ack
);
  localparam int unsigned CNT_W = SIZE_MAX + 1;

  bsq_state_e           state_q;
  logic [ADDR_W-1:0]    addr_q, addr_nxt, blk_mask, step;
  logic [BSQ_LOG_W-1:0] xfer_log_q;
  logic [CNT_W-1:0]     left_q;
  logic                 last_beat;

  always_comb begin
    blk_mask  = {ADDR_W{1'b1}} << xfer_log_q;
    step      = ADDR_W'(1) << beat_log_q;
    addr_nxt  = (addr_q & blk_mask) | ((addr_q + step) & ~blk_mask);
    last_beat = (left_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= BSQ_IDLE;
      addr_q     <= '0;
      xfer_log_q <= '0;
      port_log_q <= '0;
      beat_log_q <= '0;
      left_q     <= '0;
    end else begin
      unique case (state_q)
        BSQ_IDLE: if (accept) begin
          state_q    <= BSQ_RUN;
          addr_q     <= start_addr;
          xfer_log_q <= xfer_log;
          port_log_q <= port_log;
          beat_log_q <= beat_log;
          left_q     <= beats_m1;
        end
        BSQ_RUN: if (mem_ready) begin
          if (last_beat) begin
            state_q <= BSQ_IDLE;
          end else begin
            left_q <= left_q - CNT_W'(1);
            addr_q <= addr_nxt;
          end
        end
        default: state_q <= BSQ_IDLE;
      endcase
    end
  end

  assign busy       = (state_q == BSQ_RUN);
  assign beat_addr  = addr_q;
  assign beat_valid = busy && mem_ready;
  assign xfer_ack   = beat_valid && last_beat;

  AST_WAIT_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ready |=> busy && $stable(addr_q) && $stable(left_q)); // R7
  AST_ACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !busy); // R1
  AST_BEAT_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !xfer_ack |=> busy && (left_q == $past(left_q) - CNT_W'(1))); // R3
endmodule

// File: rtl/bsq_lane_gen.sv
module bsq_lane_gen
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 8
) (
  input  logic                 active,
  input  logic [ADDR_W-1:0]    beat_addr,
  input  logic [BSQ_LOG_W-1:0] port_log,
  input  logic [BSQ_LOG_W-1:0] beat_log,
  output logic [LANES-1:0]     lane_sel
);
  localparam int unsigned LANE_LOG = $clog2(LANES);
  localparam int unsigned IDX_W    = LANE_LOG + 2;

  logic [IDX_W-1:0] off, width, upper;

  always_comb begin
    off   = IDX_W'(beat_addr[LANE_LOG-1:0]) & ((IDX_W'(1) << port_log) - IDX_W'(1));
    width = IDX_W'(1) << beat_log;
    upper = off + width;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    assign lane_sel[i] = active && (IDX >= off) && (IDX < upper);
  end
endmodule

// File: rtl/beat_sequencer.sv
module beat_sequencer
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LANES    = 8,
  parameter int unsigned SIZE_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_port,
  input  logic              mem_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LANES-1:0]  lane_sel,
  output logic              beat_valid,
  output logic              xfer_ack
);
  logic [ADDR_W-1:0]    start_addr;
  logic [BSQ_LOG_W-1:0] xfer_log, port_log, beat_log, port_log_q, beat_log_q;
  logic [SIZE_MAX:0]    beats_m1;
  logic                 accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  bsq_req_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .SIZE_MAX(SIZE_MAX)) u_decode (
    .addr(req_addr), .size_code(req_size), .port_code(req_port),
    .start_addr(start_addr), .xfer_log(xfer_log), .port_log(port_log),
    .beat_log(beat_log), .beats_m1(beats_m1)
  );

  bsq_beat_ctrl #(.ADDR_W(ADDR_W), .SIZE_MAX(SIZE_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .start_addr(start_addr),
    .xfer_log(xfer_log), .port_log(port_log), .beat_log(beat_log),
    .beats_m1(beats_m1), .mem_ready(mem_ready), .busy(busy),
    .beat_addr(beat_addr), .port_log_q(port_log_q), .beat_log_q(beat_log_q),
    .beat_valid(beat_valid), .xfer_ack(xfer_ack)
  );

  bsq_lane_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lanes (
    .active(busy), .beat_addr(beat_addr), .port_log(port_log_q),
    .beat_log(beat_log_q), .lane_sel(lane_sel)
  );

  AST_ACK_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> beat_valid); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_sel == '0) && !beat_valid && !xfer_ack); // R6
  AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> mem_ready); // R7
  AST_LANES_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (lane_sel != '0)); // R6
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || $past(xfer_ack)); // R1
endmodule

// File: tb/beat_sequencer_tb.sv
module beat_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_port = '0;
  logic        mem_ready = 1'b0;
  logic        busy;
  logic [31:0] beat_addr;
  logic [7:0]  lane_sel;
  logic        beat_valid;
  logic        xfer_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  beat_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_port(req_port),
    .mem_ready(mem_ready), .busy(busy), .beat_addr(beat_addr),
    .lane_sel(lane_sel), .beat_valid(beat_valid), .xfer_ack(xfer_ack)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lanes(input logic [31:0] a, input int p, input int b);
    logic [7:0] m = '0;
    int off = int'(a) % p;
    for (int i = 0; i < 8; i++) if (i >= off && i < off + b) m[i] = 1'b1;
    return m;
  endfunction

  // One transfer; stall_every=k drops mem_ready on every k-th cycle (0: never)
  task automatic run_xfer(input logic [31:0] a, input logic [2:0] sz, input logic [1:0] pt,
                          input int stall_every, input bit hammer, input string tag);
    int t = 1 << ((sz > 3'd4) ? 4 : int'(sz));   // R2
    int p = 1 << int'(pt);
    int b = (t < p) ? t : p;
    int n = t / b;
    logic [31:0] ea = a & ~32'(b - 1);          // R5
    int beat = 0, cyc = 0, vcnt = 0, acnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_port = pt; mem_ready = 1'b0;
    #1 chk(req_ready == 1'b1, {"R1 ready idle ", tag}, req_ready, 1);
    @(negedge clk);
    req_valid = hammer;
    if (hammer) begin req_addr = ~a; req_size = 3'd0; req_port = 2'd3; end
    while (beat < n && cyc < 200) begin
      mem_ready = (stall_every != 0 && (cyc % stall_every) == 0) ? 1'b0 : 1'b1;
      #1;
      chk(busy == 1'b1, {"R1 busy ", tag}, busy, 1);
      chk(req_ready == 1'b0, {"R9 not ready when busy ", tag}, req_ready, 0);
      chk(beat_addr == ea, {"R5 beat addr ", tag}, beat_addr, ea);
      chk(lane_sel == exp_lanes(ea, p, b), {"R6 lanes ", tag}, lane_sel, exp_lanes(ea, p, b));
      chk(beat_valid == mem_ready, {"R7 valid vs ready ", tag}, beat_valid, mem_ready);
      chk(xfer_ack == (mem_ready && beat == n - 1), {"R4 ack ", tag}, xfer_ack,
          (mem_ready && beat == n - 1));
      if (beat_valid) vcnt++;
      if (xfer_ack) acnt++;
      if (mem_ready) begin
        beat++;
        ea = (ea & ~32'(t - 1)) | ((ea + 32'(b)) & 32'(t - 1));
      end
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0; mem_ready = 1'b1;
    #1;
    chk(vcnt == n, {"R3 beat count ", tag}, vcnt, n);
    chk(acnt == 1, {"R4 one ack ", tag}, acnt, 1);
    chk(busy == 1'b0, {"R1 idle after ack ", tag}, busy, 0);
    chk(lane_sel == 8'h00 && !beat_valid, {"R6 idle lanes ", tag}, lane_sel, 0);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(!busy && req_ready, "R8 idle after reset", {busy, req_ready}, 2'b01);
    chk(lane_sel == 8'h00 && !beat_valid && !xfer_ack, "R8 outputs quiet", lane_sel, 0);
  endtask

  task automatic t_ddw_32;   // R10
    run_xfer(32'h0000_1000, 3'd4, 2'd2, 0, 1'b0, "R10 16B on 32-bit");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_ddw_32();
    run_xfer(32'h0000_2000, 3'd3, 2'd0, 3, 1'b0, "R7 8B on 8-bit stalled");
    run_xfer(32'h0000_0105, 3'd0, 2'd3, 0, 1'b0, "R6 1B odd on 64-bit");
    run_xfer(32'h0000_0033, 3'd1, 2'd1, 2, 1'b0, "R5 2B misaligned on 16-bit");
    run_xfer(32'h0000_001C, 3'd4, 2'd2, 0, 1'b0, "R5 wrap 16B on 32-bit");
    run_xfer(32'h0000_0104, 3'd2, 2'd3, 0, 1'b0, "R6 4B upper on 64-bit");
    run_xfer(32'h0000_0040, 3'd7, 2'd3, 0, 1'b0, "R2 size clamp on 64-bit");
    run_xfer(32'h0000_0202, 3'd4, 2'd1, 4, 1'b1, "R9 hammer 16B on 16-bit");
    run_xfer(32'h0000_0008, 3'd3, 2'd3, 2, 1'b0, "R3 one beat stalled");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule